// File: doc/BRIEF.md
# UART Interrupt Identification and Priority Unit

This block merges the interrupt sources of a 16550-style serial port into one interrupt request and an 8-bit identification byte. The sources are receiver line-status errors, receive data at or above the FIFO threshold, receive character timeout, transmit holding register empty, and modem-status change. It keeps the interrupt-enable and FIFO-control settings. It holds a pending flag for each source that clears on an event. It picks the most urgent enabled source by fixed priority and encodes it.

The surrounding port logic supplies the receive FIFO fill level, a once-per-character-time tick and single-cycle event pulses. Setting events are line error, character received, holding register emptied and modem line change. Clearing events are identification read, line-status read, data read, holding register write and modem-status read. The block drives the identification byte, the interrupt line, one-cycle FIFO reset strobes, the DMA mode select and the power-down qualifier.

Top module: `uart_irq_ident`

## Requirements
- R1: After synchronous reset, `irq` is 0 and `iir` reads 0x00. All enables are off, the FIFOs are disabled, the receive threshold is 1 byte, `dma_mode` is 0, `pd_active` is 0 and both reset strobes are 0.
- R2: `iir` bit 0 is 1 exactly when an enabled source is pending, and `irq` equals it. Bits 3:1 carry the source code: 011 line status, 010 receive data, 110 timeout, 001 holding empty, 000 modem. Bits 3:1 read 000 when nothing is pending. Bits 5:4 are 0. Bits 7:6 read 11 while the FIFOs are enabled and 00 otherwise.
- R3: When several enabled sources are pending, the report follows this order: line status first, then receive data, then timeout, then holding empty, then modem status.
- R4: Enable-register write bits gate the sources: bit 0 gates receive data and timeout, bit 1 holding empty, bit 2 line status and bit 3 modem status. A masked source keeps its pending state and is reported as soon as its enable is set.
- R5: A line-error pulse makes line status pending from the next cycle. A line-status read clears it. When both arrive in the same cycle, the line-error pulse wins.
- R6: Receive data is pending while the fill level is at least the threshold, with the FIFOs enabled. FIFO-control bits 7:6 set the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. With the FIFOs disabled, any nonzero level makes receive data pending.
- R7: Timeout applies with the FIFOs enabled and a nonzero fill level. It becomes pending after 4 character ticks with no character received and no data read. A received character, a data read or an empty FIFO restarts the count.
- R8: A holding-empty pulse makes holding empty pending. A holding register write clears it. An identification read clears it only while code 001 is the one reported. A holding-empty pulse in the same cycle as a clear wins.
- R9: A modem-change pulse makes modem status pending. A modem-status read clears it. When both arrive in the same cycle, the change pulse wins.
- R10: FIFO-control write bit 0 enables the FIFOs and bit 3 drives `dma_mode`. Bit 1 produces a one-cycle `rx_fifo_rst` strobe in the cycle after the write, and bit 2 does the same for `tx_fifo_rst`.
- R11: `pd_active` is 1 only when enable-register bit 5 is set and `pd_mcr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_we | input | 1 | Write strobe for the enable register |
| fcr_we | input | 1 | Write strobe for the FIFO-control register |
| wdata | input | 8 | Write data for both registers |
| pd_mcr | input | 1 | Power-down enable from the modem control register |
| rx_count | input | CNT_W | Receive FIFO fill level |
| char_tick | input | 1 | One pulse per character time |
| rx_char_evt | input | 1 | A character was received |
| rx_rd | input | 1 | Receive data read |
| line_err_evt | input | 1 | Line error detected |
| lsr_rd | input | 1 | Line-status register read |
| thr_empty_evt | input | 1 | Transmit holding register became empty |
| thr_wr | input | 1 | Transmit holding register write |
| modem_chg_evt | input | 1 | Modem input changed |
| msr_rd | input | 1 | Modem-status register read |
| iir_rd | input | 1 | Identification register read |
| irq | output | 1 | Interrupt request |
| iir | output | 8 | Identification byte |
| rx_fifo_rst | output | 1 | Receive FIFO reset strobe |
| tx_fifo_rst | output | 1 | Transmit FIFO reset strobe |
| dma_mode | output | 1 | DMA mode select |
| pd_active | output | 1 | Power-down qualified |

## Verification
Setting and clearing a pending flag can fall in the same cycle. The bench provokes this by driving a holding-empty pulse together with an identification read while code 001 is reported, a line error together with a line-status read, and a modem change together with a modem-status read. A behavioural model compares the result on every cycle and expects the flag to stay pending. The bench also drives an identification read while a higher-priority source is reported and expects the holding-empty interrupt to survive.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        ID_MODEM   = 3'b000,
        ID_THRE    = 3'b001,
        ID_RDA     = 3'b010,
        ID_LINE    = 3'b011,
        ID_TIMEOUT = 3'b110
    } irq_id_e;

    typedef struct packed {
        logic pd;
        logic ms;
        logic ls;
        logic thre;
        logic rda;
    } irq_en_t;

    typedef struct packed {
        logic       fifo_en;
        logic       dma;
        logic [1:0] trig;
    } fifo_cfg_t;

    typedef struct packed {
        logic    pend;
        irq_id_e id;
    } irq_sel_t;

    localparam int FLG_LINE  = 0;
    localparam int FLG_THRE  = 1;
    localparam int FLG_MODEM = 2;
    localparam int NUM_FLAGS = 3;

    function automatic logic [31:0] trig_depth(input logic [1:0] code);
        case (code)
            2'b00:   return 32'd1;
            2'b01:   return 32'd4;
            2'b10:   return 32'd8;
            default: return 32'd14;
        endcase
    endfunction

    function automatic irq_en_t decode_ier(input logic [7:0] w);
        irq_en_t e;
        e.pd   = w[5];
        e.ms   = w[3];
        e.ls   = w[2];
        e.thre = w[1];
        e.rda  = w[0];
        return e;
    endfunction

    function automatic logic [7:0] encode_iir(input irq_sel_t s, input logic fen);
        return {{2{fen}}, 2'b00, s.id, s.pend};
    endfunction

endpackage

// File: rtl/uart_irq_cfg.sv
module uart_irq_cfg
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ier_we,
    input  logic       fcr_we,
    input  logic [7:0] wdata,
    output irq_en_t    en_q,
    output fifo_cfg_t  fcfg_q,
    output logic       rx_rst_q,
    output logic       tx_rst_q
);
    logic unused_wdata_b4;
    assign unused_wdata_b4 = wdata[4];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            fcfg_q   <= '0;
            rx_rst_q <= 1'b0;
            tx_rst_q <= 1'b0;
        end else begin
            rx_rst_q <= fcr_we & wdata[1];
            tx_rst_q <= fcr_we & wdata[2];
            if (ier_we) en_q <= decode_ier(wdata);
            if (fcr_we) begin
                fcfg_q.fifo_en <= wdata[0];
                fcfg_q.dma     <= wdata[3];
                fcfg_q.trig    <= wdata[7:6];
            end
        end
    end
endmodule

// File: rtl/uart_irq_flag.sv
module uart_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    always_ff @(posedge clk) begin
        if (rst)        pend_o <= 1'b0;
        else if (set_i) pend_o <= 1'b1;
        else if (clr_i) pend_o <= 1'b0;
    end
endmodule

// File: rtl/uart_irq_rx_timer.sv
module uart_irq_rx_timer #(
    parameter int TO_CHARS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic restart_i,
    input  logic tick_i,
    output logic expired_o
);
    localparam int TO_W = $clog2(TO_CHARS + 1);
    localparam logic [TO_W-1:0] LIMIT = TO_W'(TO_CHARS);

    logic [TO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !arm_i || restart_i) cnt_q <= '0;
        else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/uart_irq_arb.sv
module uart_irq_arb
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  irq_en_t          en,
    input  fifo_cfg_t        fcfg,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             line_p,
    input  logic             thre_p,
    input  logic             modem_p,
    input  logic             timeout_p,
    output irq_sel_t         sel
);
    logic [31:0] level;
    logic        rda_p;
    logic        to_p;

    assign level = 32'(rx_count);
    assign rda_p = fcfg.fifo_en ? (level >= trig_depth(fcfg.trig)) : (rx_count != '0);
    assign to_p  = fcfg.fifo_en & timeout_p;

    always_comb begin
        sel.pend = 1'b1;
        sel.id   = ID_MODEM;
        if (en.ls && line_p)         sel.id = ID_LINE;
        else if (en.rda && rda_p)    sel.id = ID_RDA;
        else if (en.rda && to_p)     sel.id = ID_TIMEOUT;
        else if (en.thre && thre_p)  sel.id = ID_THRE;
        else if (en.ms && modem_p)   sel.id = ID_MODEM;
        else                         sel.pend = 1'b0;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int TO_CHARS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ier_we,
    input  logic             fcr_we,
    input  logic [7:0]       wdata,
    input  logic             pd_mcr,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             char_tick,
    input  logic             rx_char_evt,
    input  logic             rx_rd,
    input  logic             line_err_evt,
    input  logic             lsr_rd,
    input  logic             thr_empty_evt,
    input  logic             thr_wr,
    input  logic             modem_chg_evt,
    input  logic             msr_rd,
    input  logic             iir_rd,
    output logic             irq,
    output logic [7:0]       iir,
    output logic             rx_fifo_rst,
    output logic             tx_fifo_rst,
    output logic             dma_mode,
    output logic             pd_active
);
    irq_en_t   en_q;
    fifo_cfg_t fcfg_q;
    irq_sel_t  sel;
    logic      timeout_p;

    logic [NUM_FLAGS-1:0] flg_set;
    logic [NUM_FLAGS-1:0] flg_clr;
    logic [NUM_FLAGS-1:0] flg_pend;

    uart_irq_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .ier_we   (ier_we),
        .fcr_we   (fcr_we),
        .wdata    (wdata),
        .en_q     (en_q),
        .fcfg_q   (fcfg_q),
        .rx_rst_q (rx_fifo_rst),
        .tx_rst_q (tx_fifo_rst)
    );

    assign flg_set[FLG_LINE]  = line_err_evt;
    assign flg_clr[FLG_LINE]  = lsr_rd;
    assign flg_set[FLG_THRE]  = thr_empty_evt;
    assign flg_clr[FLG_THRE]  = thr_wr | (iir_rd & sel.pend & (sel.id == ID_THRE));
    assign flg_set[FLG_MODEM] = modem_chg_evt;
    assign flg_clr[FLG_MODEM] = msr_rd;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        uart_irq_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (flg_set[g]),
            .clr_i  (flg_clr[g]),
            .pend_o (flg_pend[g])
        );
    end

    uart_irq_rx_timer #(.TO_CHARS(TO_CHARS)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .arm_i     (fcfg_q.fifo_en && (rx_count != '0)),
        .restart_i (rx_char_evt | rx_rd),
        .tick_i    (char_tick),
        .expired_o (timeout_p)
    );

    uart_irq_arb #(.CNT_W(CNT_W)) u_arb (
        .en        (en_q),
        .fcfg      (fcfg_q),
        .rx_count  (rx_count),
        .line_p    (flg_pend[FLG_LINE]),
        .thre_p    (flg_pend[FLG_THRE]),
        .modem_p   (flg_pend[FLG_MODEM]),
        .timeout_p (timeout_p),
        .sel       (sel)
    );

    assign iir       = encode_iir(sel, fcfg_q.fifo_en);
    assign irq       = sel.pend;
    assign dma_mode  = fcfg_q.dma;
    assign pd_active = en_q.pd & pd_mcr;
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst,
    input logic       fcr_we,
    input logic [7:0] wdata,
    input logic       pd_mcr,
    input logic       line_err_evt,
    input logic       lsr_rd,
    input logic       thr_empty_evt,
    input logic       thr_wr,
    input logic       modem_chg_evt,
    input logic       msr_rd,
    input logic [7:0] iir,
    input logic       rx_fifo_rst,
    input logic       pd_active
);
    AST_LSR_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        lsr_rd && !line_err_evt |=> iir[3:1] != 3'b011);  // R5

    AST_THR_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        thr_wr && !thr_empty_evt |=> !(iir[0] && iir[3:1] == 3'b001));  // R8

    AST_MSR_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        msr_rd && !modem_chg_evt |=> !(iir[0] && iir[3:1] == 3'b000));  // R9

    AST_FIFO_FIELD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        fcr_we |=> iir[7:6] == {2{$past(wdata[0])}});  // R2

    AST_NO_TIMEOUT_UNBUFFERED: assert property (@(posedge clk) disable iff (rst)
        iir[7:6] == 2'b00 |-> iir[3:1] != 3'b110);  // R7

    AST_RX_RESET_STROBE: assert property (@(posedge clk) disable iff (rst)
        fcr_we && wdata[1] |=> rx_fifo_rst);  // R10

    AST_PD_NEEDS_MCR: assert property (@(posedge clk) disable iff (rst)
        pd_active |-> pd_mcr);  // R11
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .fcr_we        (fcr_we),
    .wdata         (wdata),
    .pd_mcr        (pd_mcr),
    .line_err_evt  (line_err_evt),
    .lsr_rd        (lsr_rd),
    .thr_empty_evt (thr_empty_evt),
    .thr_wr        (thr_wr),
    .modem_chg_evt (modem_chg_evt),
    .msr_rd        (msr_rd),
    .iir           (iir),
    .rx_fifo_rst   (rx_fifo_rst),
    .pd_active     (pd_active)
);

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst = 1'b1;
    logic             ier_we = 0, fcr_we = 0, pd_mcr = 0;
    logic [7:0]       wdata = 0;
    logic [CNT_W-1:0] rx_count = 0;
    logic char_tick = 0, rx_char_evt = 0, rx_rd = 0, line_err_evt = 0, lsr_rd = 0;
    logic thr_empty_evt = 0, thr_wr = 0, modem_chg_evt = 0, msr_rd = 0, iir_rd = 0;
    logic       irq, rx_fifo_rst, tx_fifo_rst, dma_mode, pd_active;
    logic [7:0] iir;

    uart_irq_ident #(.CNT_W(CNT_W), .TO_CHARS(4)) dut_i (
        .clk(clk), .rst(rst), .ier_we(ier_we), .fcr_we(fcr_we), .wdata(wdata),
        .pd_mcr(pd_mcr), .rx_count(rx_count), .char_tick(char_tick),
        .rx_char_evt(rx_char_evt), .rx_rd(rx_rd), .line_err_evt(line_err_evt),
        .lsr_rd(lsr_rd), .thr_empty_evt(thr_empty_evt), .thr_wr(thr_wr),
        .modem_chg_evt(modem_chg_evt), .msr_rd(msr_rd), .iir_rd(iir_rd),
        .irq(irq), .iir(iir), .rx_fifo_rst(rx_fifo_rst), .tx_fifo_rst(tx_fifo_rst),
        .dma_mode(dma_mode), .pd_active(pd_active)
    );

    int    checks = 0;
    int    failures = 0;
    string tag = "R1";
    bit    finished = 0;

    // behavioural reference state
    bit [7:0] m_ier = 0;
    bit       m_fen = 0, m_dma = 0, m_ls = 0, m_thre = 0, m_ms = 0, m_rxp = 0, m_txp = 0;
    bit [1:0] m_trig = 0;
    int       m_to = 0;

    function automatic int depth_of(bit [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit [7:0] exp_iir();
        bit       rda, tmo;
        bit [2:0] id;
        bit       p;
        rda = m_fen ? (int'(rx_count) >= depth_of(m_trig)) : (rx_count != 0);
        tmo = m_fen && (m_to >= 4);
        p = 1; id = 3'b000;
        if (m_ier[2] && m_ls)        id = 3'b011;
        else if (m_ier[0] && rda)    id = 3'b010;
        else if (m_ier[0] && tmo)    id = 3'b110;
        else if (m_ier[1] && m_thre) id = 3'b001;
        else if (m_ier[3] && m_ms)   id = 3'b000;
        else                         p = 0;
        return {{2{m_fen}}, 2'b00, id, p};
    endfunction

    always @(posedge clk) begin
        bit [7:0] cur;
        cur = exp_iir();
        if (rst) begin
            m_ier = 0; m_fen = 0; m_dma = 0; m_trig = 0; m_ls = 0; m_thre = 0;
            m_ms = 0; m_rxp = 0; m_txp = 0; m_to = 0;
        end else begin
            if (rx_char_evt || rx_rd || rx_count == 0 || !m_fen) m_to = 0;
            else if (char_tick && m_to < 4) m_to = m_to + 1;
            if (line_err_evt) m_ls = 1; else if (lsr_rd) m_ls = 0;
            if (thr_empty_evt) m_thre = 1;
            else if (thr_wr || (iir_rd && cur[0] && cur[3:1] == 3'b001)) m_thre = 0;
            if (modem_chg_evt) m_ms = 1; else if (msr_rd) m_ms = 0;
            m_rxp = fcr_we & wdata[1];
            m_txp = fcr_we & wdata[2];
            if (ier_we) m_ier = wdata & 8'h2F;
            if (fcr_we) begin
                m_fen = wdata[0]; m_dma = wdata[3]; m_trig = wdata[7:6];
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cmp_all();
        bit [7:0] e;
        e = exp_iir();
        chk(tag, 32'(iir), 32'(e), "iir");
        chk(tag, 32'(irq), 32'(e[0]), "irq");
        chk(tag, 32'(rx_fifo_rst), 32'(m_rxp), "rx_fifo_rst");
        chk(tag, 32'(tx_fifo_rst), 32'(m_txp), "tx_fifo_rst");
        chk(tag, 32'(dma_mode), 32'(m_dma), "dma_mode");
        chk(tag, 32'(pd_active), 32'(m_ier[5] & pd_mcr), "pd_active");
    endtask

    task automatic cyc();
        #1 cmp_all();
        @(posedge clk);
        @(negedge clk);
        ier_we = 0; fcr_we = 0; char_tick = 0; rx_char_evt = 0; rx_rd = 0;
        line_err_evt = 0; lsr_rd = 0; thr_empty_evt = 0; thr_wr = 0;
        modem_chg_evt = 0; msr_rd = 0; iir_rd = 0;
    endtask

    task automatic expect_iir(string req, logic [7:0] v);
        #1 chk(req, 32'(iir), 32'(v), "iir named");
    endtask

    task automatic wr_ier(logic [7:0] v);
        ier_we = 1; wdata = v; cyc();
    endtask

    task automatic wr_fcr(logic [7:0] v);
        fcr_we = 1; wdata = v; cyc();
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        pd_mcr = 1;
        @(posedge clk); @(negedge clk);
        cyc(); cyc();
        rst = 0;
        cyc();
        expect_iir("R1", 8'h00);
        chk("R1", 32'(irq), 0, "irq after reset");
        chk("R1", 32'(pd_active), 0, "pd_active after reset");
        pd_mcr = 0;

        // R3/R5/R8/R9 with FIFOs disabled
        tag = "R3";
        wr_ier(8'h0F);
        line_err_evt = 1; thr_empty_evt = 1; cyc();
        expect_iir("R3", 8'h07);
        tag = "R5";
        lsr_rd = 1; cyc();
        expect_iir("R5", 8'h03);
        tag = "R8";
        iir_rd = 1; cyc();
        expect_iir("R8", 8'h00);
        tag = "R9";
        modem_chg_evt = 1; cyc();
        expect_iir("R9", 8'h01);
        msr_rd = 1; cyc();
        expect_iir("R9", 8'h00);

        // R6 unbuffered and R8 id read while a higher source is reported
        tag = "R6";
        thr_empty_evt = 1; rx_count = 1; cyc();
        expect_iir("R6", 8'h05);
        tag = "R8";
        iir_rd = 1; cyc();
        rx_count = 0; cyc();
        expect_iir("R8", 8'h03);
        thr_wr = 1; cyc();
        expect_iir("R8", 8'h00);

        // same-cycle set and clear
        thr_empty_evt = 1; cyc();
        iir_rd = 1; thr_empty_evt = 1; cyc();
        expect_iir("R8", 8'h03);
        tag = "R5";
        line_err_evt = 1; cyc();
        line_err_evt = 1; lsr_rd = 1; cyc();
        expect_iir("R5", 8'h07);
        lsr_rd = 1; thr_wr = 1; cyc();
        expect_iir("R5", 8'h00);
        tag = "R9";
        modem_chg_evt = 1; cyc();
        modem_chg_evt = 1; msr_rd = 1; cyc();
        expect_iir("R9", 8'h01);
        msr_rd = 1; cyc();

        // R4 masking keeps pending state
        tag = "R4";
        wr_ier(8'h00);
        line_err_evt = 1; thr_empty_evt = 1; modem_chg_evt = 1; rx_count = 1; cyc();
        expect_iir("R4", 8'h00);
        chk("R4", 32'(irq), 0, "irq while masked");
        wr_ier(8'h08); expect_iir("R4", 8'h01);
        wr_ier(8'h0A); expect_iir("R4", 8'h03);
        wr_ier(8'h0B); expect_iir("R4", 8'h05);
        wr_ier(8'h0F); expect_iir("R4", 8'h07);
        lsr_rd = 1; thr_wr = 1; msr_rd = 1; rx_count = 0; cyc();
        expect_iir("R4", 8'h00);

        // R6 thresholds
        tag = "R6";
        wr_ier(8'h01);
        for (int c = 0; c < 4; c++) begin
            wr_fcr({2'(c), 6'b000001});
            rx_count = CNT_W'(depth_of(2'(c)) - 1); cyc();
            expect_iir("R6", 8'hC0);
            rx_count = CNT_W'(depth_of(2'(c))); cyc();
            expect_iir("R6", 8'hC5);
            rx_count = 0; cyc();
        end

        // R7 timeout
        tag = "R7";
        wr_fcr(8'hC1);
        rx_count = 3;
        for (int i = 0; i < 4; i++) begin
            char_tick = 1; cyc();
            if (i == 2) expect_iir("R7", 8'hC0);
        end
        expect_iir("R7", 8'hCD);
        rx_rd = 1; rx_count = 2; cyc();
        expect_iir("R7", 8'hC0);
        for (int i = 0; i < 4; i++) begin char_tick = 1; cyc(); end
        expect_iir("R7", 8'hCD);
        rx_char_evt = 1; rx_count = 3; cyc();
        expect_iir("R7", 8'hC0);
        for (int i = 0; i < 2; i++) begin char_tick = 1; cyc(); end
        rx_count = 0; cyc();
        rx_count = 3;
        for (int i = 0; i < 2; i++) begin char_tick = 1; cyc(); end
        expect_iir("R7", 8'hC0);
        tag = "R3";
        wr_fcr(8'h41);
        for (int i = 0; i < 4; i++) begin char_tick = 1; cyc(); end
        expect_iir("R3", 8'hCD);
        rx_count = 4; cyc();
        expect_iir("R3", 8'hC5);
        tag = "R7";
        wr_fcr(8'h00);
        rx_count = 3;
        wr_ier(8'h00);
        for (int i = 0; i < 5; i++) begin char_tick = 1; cyc(); end
        rx_count = 0; cyc();

        // R10 FIFO control strobes
        tag = "R10";
        wr_fcr(8'h0F);
        #1 chk("R10", 32'(rx_fifo_rst), 1, "rx strobe");
        chk("R10", 32'(tx_fifo_rst), 1, "tx strobe");
        chk("R10", 32'(dma_mode), 1, "dma");
        cyc();
        chk("R10", 32'(rx_fifo_rst), 0, "rx strobe ends");
        wr_fcr(8'h03);
        #1 chk("R10", 32'(tx_fifo_rst), 0, "tx strobe idle");
        chk("R10", 32'(dma_mode), 0, "dma off");
        chk("R2", 32'(iir[7:6]), 3, "fifo field");
        cyc();

        // R11 power-down qualification
        tag = "R11";
        pd_mcr = 1; wr_ier(8'h20);
        #1 chk("R11", 32'(pd_active), 1, "pd both set");
        pd_mcr = 0; cyc();
        chk("R11", 32'(pd_active), 0, "pd without mcr");
        pd_mcr = 1; wr_ier(8'h00);
        #1 chk("R11", 32'(pd_active), 0, "pd without ier");
        cyc();

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule